// File: doc/BRIEF.md
# Scheduled-Traffic Transmit Timestamp Logger

This block sits beside the transmit side of several ports that run under a time-aware gate scheduler. Each port reports when a frame starts to go out, with the frame's priority and sequence number. The logger stamps that moment with the free-running 64-bit time input. It keeps the resulting event, tagged with its port number, in one bounded pool that all ports share. Software later checks whether each frame left inside the gate interval that matches its priority.

Capture is switched on or off per port. Each port also picks a filter. One mode logs every frame start. The other logs only the first frame start after the port's schedule signals the start of a new gate interval. Every stored event raises a one-cycle interrupt request for its port. Software drains the pool through a lookup that names a port. The lookup returns that port's oldest event and removes it, and events of other ports stay where they are.

Top module: `ts_event_logger`

## Requirements
- R1: After reset the pool is empty, `ovf` is 0, every `irq` bit is 0 and `lk_valid` is 0. A lookup for any port then answers with `lk_hit` = 0.
- R2: While `cap_en[p]` is 0, a frame-start strobe on port p stores nothing and leaves `irq[p]` at 0.
- R3: With `cap_first[p]` = 0 (log-all mode), every strobe on an enabled port p stores one event. The event holds p, `tx_prio` slice p (bits `p*PRIOW +: PRIOW`), `tx_seq` slice p (bits `p*SEQW +: SEQW`) and the `time_now` value present at the clock edge that samples the strobe.
- R4: With `cap_first[p]` = 1 (first-frame mode), only the first strobe after reset, or after an `ivl_start[p]` pulse, is stored. A strobe in the same cycle as `ivl_start[p]` counts as the first frame of the new interval.
- R5: `lk_req` with `lk_port` = p gives `lk_valid` = 1 on the next cycle. `lk_hit` is 1 exactly when port p had an event. The returned event is the oldest stored one for port p, and it is removed. Events of other ports keep their order.
- R6: Strobes from several ports in the same cycle are all stored in that cycle, in ascending port order. Each such port gets its own `irq` pulse.
- R7: The pool holds DEPTH events (default 32) in total across all ports. An event that finds the pool full is dropped, its `irq` bit stays 0, and `ovf` rises and stays 1 until reset. Room freed by a lookup is available again from the next cycle.
- R8: `irq[p]` is a one-cycle pulse on the cycle after the edge that stored an event for port p, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_en | input | NPORT | Per-port capture enable |
| cap_first | input | NPORT | Per-port filter: 0 logs all frames, 1 logs the first frame per interval |
| tx_start | input | NPORT | Per-port frame transmit-start strobe |
| tx_prio | input | NPORT*PRIOW | Per-port frame priority, port p in bits p*PRIOW +: PRIOW |
| tx_seq | input | NPORT*SEQW | Per-port frame sequence id, port p in bits p*SEQW +: SEQW |
| ivl_start | input | NPORT | Per-port gate-interval start pulse |
| time_now | input | TSW | Current time |
| lk_req | input | 1 | Lookup request |
| lk_port | input | PW | Port named by the lookup |
| lk_valid | output | 1 | Lookup answer present |
| lk_hit | output | 1 | Lookup found an event |
| lk_prio | output | PRIOW | Priority of the returned event |
| lk_seq | output | SEQW | Sequence id of the returned event |
| lk_time | output | TSW | Timestamp of the returned event |
| irq | output | NPORT | Per-port event-stored interrupt pulse |
| ovf | output | 1 | Sticky pool overflow flag |

## Verification
The assertions check on every cycle that a lookup is answered on the next cycle and that a hit only appears inside an answer. They also check that overflow never falls, that a disabled or idle port never raises its interrupt, and that first-frame mode never stores two consecutive frames of one interval. Only the bench scenarios can show what the pool actually contains: the stored fields and timestamps, the oldest-first order per port, ascending port order for simultaneous frames, and the exact frame at which the pool fills, including a cycle where one port is stored and the next is dropped.

// File: rtl/ts_log_pkg.sv
package ts_log_pkg;

   typedef enum logic {
      CAP_ALL   = 1'b0,
      CAP_FIRST = 1'b1
   } cap_mode_e;

   function automatic int idx_bits(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ts_capture_filter.sv
module ts_capture_filter
   import ts_log_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic first_mode,
   input  logic start,
   input  logic ivl,
   output logic capt
);

   cap_mode_e mode;
   logic      taken_q;

   assign mode = cap_mode_e'(first_mode);

   // a frame together with the interval pulse belongs to the new interval
   always_comb begin
      capt = 1'b0;
      if (en && start) begin
         unique case (mode)
            CAP_ALL:   capt = 1'b1;
            CAP_FIRST: capt = ivl || !taken_q;
            default:   capt = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)   taken_q <= 1'b0;
      else if (ivl) taken_q <= capt;
      else          taken_q <= taken_q | capt;
   end

endmodule

// File: rtl/ts_event_pool.sv
module ts_event_pool #(
   parameter int NPORT = 4,
   parameter int DEPTH = 32,
   parameter int PRIOW = 3,
   parameter int SEQW  = 16,
   parameter int TSW   = 64,
   localparam int PW   = ts_log_pkg::idx_bits(NPORT),
   localparam int IW   = ts_log_pkg::idx_bits(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT-1:0]       wr,
   input  logic [NPORT*PRIOW-1:0] wr_prio,
   input  logic [NPORT*SEQW-1:0]  wr_seq,
   input  logic [TSW-1:0]         wr_ts,
   input  logic                   lk_req,
   input  logic [PW-1:0]          lk_port,
   output logic [NPORT-1:0]       acc,
   output logic                   lk_valid,
   output logic                   lk_hit,
   output logic [PRIOW-1:0]       lk_prio,
   output logic [SEQW-1:0]        lk_seq,
   output logic [TSW-1:0]         lk_time,
   output logic                   ovf
);

   logic [PW-1:0]    port_q [DEPTH];
   logic [PRIOW-1:0] prio_q [DEPTH];
   logic [SEQW-1:0]  seq_q  [DEPTH];
   logic [TSW-1:0]   ts_q   [DEPTH];
   logic [PW-1:0]    port_d [DEPTH];
   logic [PRIOW-1:0] prio_d [DEPTH];
   logic [SEQW-1:0]  seq_d  [DEPTH];
   logic [TSW-1:0]   ts_d   [DEPTH];
   logic [CW-1:0]    cnt_q, cnt_d;
   logic             hit;
   logic [IW-1:0]    idx;
   logic             drop;

   always_comb begin
      port_d = port_q;
      prio_d = prio_q;
      seq_d  = seq_q;
      ts_d   = ts_q;
      cnt_d  = cnt_q;
      hit    = 1'b0;
      idx    = '0;
      acc    = '0;
      drop   = 1'b0;
      // oldest entry of the named port: lowest occupied slot that matches
      for (int i = 0; i < DEPTH; i++) begin
         if (!hit && (CW'(i) < cnt_q) && (port_q[i] == lk_port)) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
      if (lk_req && hit) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (IW'(i) >= idx) begin
               port_d[i] = port_q[i+1];
               prio_d[i] = prio_q[i+1];
               seq_d[i]  = seq_q[i+1];
               ts_d[i]   = ts_q[i+1];
            end
         end
         cnt_d = cnt_q - CW'(1);
      end
      for (int p = 0; p < NPORT; p++) begin
         if (wr[p]) begin
            if (cnt_d < CW'(DEPTH)) begin
               port_d[cnt_d[IW-1:0]] = PW'(p);
               prio_d[cnt_d[IW-1:0]] = wr_prio[p*PRIOW +: PRIOW];
               seq_d[cnt_d[IW-1:0]]  = wr_seq[p*SEQW +: SEQW];
               ts_d[cnt_d[IW-1:0]]   = wr_ts;
               acc[p] = 1'b1;
               cnt_d  = cnt_d + CW'(1);
            end else begin
               drop = 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      port_q <= port_d;
      prio_q <= prio_d;
      seq_q  <= seq_d;
      ts_q   <= ts_d;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         ovf      <= 1'b0;
         lk_valid <= 1'b0;
         lk_hit   <= 1'b0;
         lk_prio  <= '0;
         lk_seq   <= '0;
         lk_time  <= '0;
      end else begin
         cnt_q    <= cnt_d;
         ovf      <= ovf | drop;
         lk_valid <= lk_req;
         lk_hit   <= lk_req & hit;
         if (lk_req && hit) begin
            lk_prio <= prio_q[idx];
            lk_seq  <= seq_q[idx];
            lk_time <= ts_q[idx];
         end
      end
   end

endmodule

// File: rtl/ts_event_logger.sv
module ts_event_logger #(
   parameter int NPORT = 4,
   parameter int DEPTH = 32,
   parameter int PRIOW = 3,
   parameter int SEQW  = 16,
   parameter int TSW   = 64,
   localparam int PW   = ts_log_pkg::idx_bits(NPORT)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT-1:0]       cap_en,
   input  logic [NPORT-1:0]       cap_first,
   input  logic [NPORT-1:0]       tx_start,
   input  logic [NPORT*PRIOW-1:0] tx_prio,
   input  logic [NPORT*SEQW-1:0]  tx_seq,
   input  logic [NPORT-1:0]       ivl_start,
   input  logic [TSW-1:0]         time_now,
   input  logic                   lk_req,
   input  logic [PW-1:0]          lk_port,
   output logic                   lk_valid,
   output logic                   lk_hit,
   output logic [PRIOW-1:0]       lk_prio,
   output logic [SEQW-1:0]        lk_seq,
   output logic [TSW-1:0]         lk_time,
   output logic [NPORT-1:0]       irq,
   output logic                   ovf
);

   if (NPORT < 2 || NPORT > 16) begin : g_bad_nport
      $error("ts_event_logger: NPORT must be within 2..16");
   end
   if (DEPTH < 2 || DEPTH > 256) begin : g_bad_depth
      $error("ts_event_logger: DEPTH must be within 2..256");
   end
   if (PRIOW < 1 || SEQW < 1 || TSW < 8) begin : g_bad_width
      $error("ts_event_logger: field widths too small");
   end

   logic [NPORT-1:0] capt;
   logic [NPORT-1:0] acc;

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      ts_capture_filter u_filt (
         .clk        (clk),
         .rst_n      (rst_n),
         .en         (cap_en[p]),
         .first_mode (cap_first[p]),
         .start      (tx_start[p]),
         .ivl        (ivl_start[p]),
         .capt       (capt[p])
      );
   end

   ts_event_pool #(
      .NPORT (NPORT),
      .DEPTH (DEPTH),
      .PRIOW (PRIOW),
      .SEQW  (SEQW),
      .TSW   (TSW)
   ) u_pool (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (capt),
      .wr_prio  (tx_prio),
      .wr_seq   (tx_seq),
      .wr_ts    (time_now),
      .lk_req   (lk_req),
      .lk_port  (lk_port),
      .acc      (acc),
      .lk_valid (lk_valid),
      .lk_hit   (lk_hit),
      .lk_prio  (lk_prio),
      .lk_seq   (lk_seq),
      .lk_time  (lk_time),
      .ovf      (ovf)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= '0;
      else        irq <= acc;
   end

endmodule

// File: rtl/ts_event_logger_chk.sv
module ts_event_logger_chk #(
   parameter int NPORT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPORT-1:0] cap_en,
   input logic [NPORT-1:0] cap_first,
   input logic [NPORT-1:0] tx_start,
   input logic [NPORT-1:0] ivl_start,
   input logic             lk_req,
   input logic             lk_valid,
   input logic             lk_hit,
   input logic [NPORT-1:0] irq,
   input logic             ovf
);

   p_lk_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> lk_valid);

   p_lk_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !lk_valid);

   p_hit_in_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> lk_valid);

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);

   for (genvar p = 0; p < NPORT; p++) begin : g_chk
      p_no_irq_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!cap_en[p] || !tx_start[p]) |=> !irq[p]);

      p_one_per_ivl_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (irq[p] && cap_first[p] && tx_start[p] && !ivl_start[p]) |=> !irq[p]);
   end

endmodule

bind ts_event_logger ts_event_logger_chk #(.NPORT(NPORT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cap_en    (cap_en),
   .cap_first (cap_first),
   .tx_start  (tx_start),
   .ivl_start (ivl_start),
   .lk_req    (lk_req),
   .lk_valid  (lk_valid),
   .lk_hit    (lk_hit),
   .irq       (irq),
   .ovf       (ovf)
);

// File: tb/sim_ts_event_logger.sv
`timescale 1ns/1ps
module sim_ts_event_logger;

   localparam int NP = 4;
   localparam int DP = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    cap_en = '0, cap_first = '0, tx_start = '0, ivl_start = '0;
   logic [11:0]   tx_prio = '0;
   logic [63:0]   tx_seq = '0;
   logic [63:0]   time_now = 64'd1000;
   logic          lk_req = 1'b0;
   logic [1:0]    lk_port = '0;
   logic          lk_valid, lk_hit, ovf;
   logic [2:0]    lk_prio;
   logic [15:0]   lk_seq;
   logic [63:0]   lk_time;
   logic [3:0]    irq;

   always #4 clk = ~clk;

   ts_event_logger u0 (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_first(cap_first),
      .tx_start(tx_start), .tx_prio(tx_prio), .tx_seq(tx_seq),
      .ivl_start(ivl_start), .time_now(time_now), .lk_req(lk_req),
      .lk_port(lk_port), .lk_valid(lk_valid), .lk_hit(lk_hit),
      .lk_prio(lk_prio), .lk_seq(lk_seq), .lk_time(lk_time),
      .irq(irq), .ovf(ovf)
   );

   typedef struct {
      int     port;
      int     prio;
      int     seq;
      longint ts;
   } ev_t;

   ev_t  mq[$];
   bit   tk[4];
   bit   m_ovf;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 1'b0;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s act=%0d exp=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      time_now = time_now + 64'd8;
   endtask

   // drive one cycle of strobes; base gives prio and seq arithmetically
   task automatic drive(input logic [3:0] st, input logic [3:0] iv, input int base, input string req);
      logic [3:0] exp_irq = '0;
      longint t0 = longint'(time_now);
      for (int p = 0; p < NP; p++) begin
         tx_prio[p*3 +: 3]  = 3'((base + p) % 8);
         tx_seq[p*16 +: 16] = 16'(base * 4 + p);
      end
      tx_start  = st;
      ivl_start = iv;
      for (int p = 0; p < NP; p++) begin
         bit c = cap_en[p] && st[p] && (!cap_first[p] || iv[p] || !tk[p]);
         if (iv[p]) tk[p] = c;
         else       tk[p] = tk[p] | c;
         if (c) begin
            if (mq.size() < DP) begin
               ev_t e;
               e.port = p; e.prio = (base + p) % 8; e.seq = (base * 4 + p) & 16'hFFFF; e.ts = t0;
               mq.push_back(e);
               exp_irq[p] = 1'b1;
            end else begin
               m_ovf = 1'b1;
            end
         end
      end
      tick();
      tx_start  = '0;
      ivl_start = '0;
      chk({req, " irq"}, longint'(irq), longint'(exp_irq));
      chk({req, " ovf"}, longint'(ovf), longint'(m_ovf));
   endtask

   task automatic lookup(input int port, input string req);
      int k = -1;
      for (int i = 0; i < mq.size(); i++) if (k < 0 && mq[i].port == port) k = i;
      lk_req  = 1'b1;
      lk_port = 2'(port);
      tick();
      lk_req = 1'b0;
      chk({req, " lk_valid"}, longint'(lk_valid), 1);
      chk({req, " lk_hit"}, longint'(lk_hit), (k >= 0) ? 1 : 0);
      if (k >= 0) begin
         chk({req, " lk_prio"}, longint'(lk_prio), longint'(mq[k].prio));
         chk({req, " lk_seq"}, longint'(lk_seq), longint'(mq[k].seq));
         chk({req, " lk_time"}, longint'(lk_time), mq[k].ts);
         mq.delete(k);
      end
      tick();
      chk({req, " lk_valid low"}, longint'(lk_valid), 0);
   endtask

   task automatic drain(input bit reverse, input string req);
      for (int j = 0; j < NP; j++) begin
         int p = reverse ? (NP - 1 - j) : j;
         int n = 0;
         foreach (mq[i]) if (mq[i].port == p) n++;
         for (int r = 0; r <= n; r++) lookup(p, req);
      end
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog act=running exp=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();
      // R1: reset state
      chk("R1 irq", longint'(irq), 0);
      chk("R1 ovf", longint'(ovf), 0);
      chk("R1 lk_valid", longint'(lk_valid), 0);
      for (int p = 0; p < NP; p++) lookup(p, "R1 empty");

      // R3 / R8: log-all mode, single-port strobes
      cap_en = 4'b1111;
      cap_first = 4'b0000;
      for (int i = 0; i < 9; i++) drive(4'(1 << (i % 4)), 4'b0000, i, "R3");
      drive(4'b0000, 4'b0000, 0, "R8 idle");
      drain(1'b0, "R5");

      // R2: disabled port ignored, neighbour still logged
      cap_en = 4'b1101;
      drive(4'b0010, 4'b0000, 20, "R2");
      drive(4'b0011, 4'b0000, 21, "R2");
      lookup(1, "R2 no event");
      drain(1'b0, "R2");
      cap_en = 4'b1111;

      // R4: first-frame mode on port 2
      cap_first = 4'b0100;
      drive(4'b0100, 4'b0100, 30, "R4");
      drive(4'b0100, 4'b0000, 31, "R4");
      drive(4'b0100, 4'b0000, 32, "R4");
      drive(4'b0000, 4'b0100, 33, "R4");
      drive(4'b0100, 4'b0000, 34, "R4");
      drive(4'b0100, 4'b0100, 35, "R4");
      drive(4'b0100, 4'b0000, 36, "R4");
      drive(4'b0001, 4'b0000, 37, "R4");
      drain(1'b0, "R4");
      cap_first = 4'b0000;

      // R6: simultaneous strobes
      drive(4'b1111, 4'b0000, 40, "R6");
      drive(4'b1010, 4'b0000, 41, "R6");
      drive(4'b0101, 4'b0000, 42, "R6");
      drain(1'b1, "R6");

      // R7: fill the shared pool, split a simultaneous pair at the boundary
      for (int i = 0; i < DP - 1; i++) drive(4'(1 << (i % 4)), 4'b0000, 50 + i, "R7");
      drive(4'b0011, 4'b0000, 90, "R7 edge");
      drive(4'b1000, 4'b0000, 91, "R7 full");
      lookup(2, "R7");
      drive(4'b1000, 4'b0000, 92, "R7 room");
      drive(4'b0100, 4'b0000, 93, "R7 full again");
      drain(1'b0, "R7");
      chk("R7 ovf sticky", longint'(ovf), 1);
      drive(4'b0010, 4'b0000, 94, "R7 after drain");
      drain(1'b1, "R7");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule